// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Engine with Descriptor Chaining

This block is the data-moving core of a small DMA controller. It holds a set of channel contexts (source address, destination address, next-descriptor pointer, control word and configuration word) that a host loads through a simple write port. It walks the channels in a fixed rotation. Whenever it finds a channel that is allowed to run, it copies one element from that channel's source address to its destination address over a single memory request port. It then updates the channel's addresses and remaining count.

When a channel's count runs out, the engine either follows the channel's pointer to a four-word descriptor in memory and reloads the context from it, or it switches the channel off. It can also raise a one-cycle terminal-count pulse for that channel. Peripheral request lines gate each channel according to a flow-control code in its configuration word. This lets a channel wait on its source peripheral, its destination peripheral, both, or neither.

Top module: `dma_xfer_engine`

## Requirements
- R1: A channel moves data only when `glb_en` is 1, its configuration bit 0 (enable) is 1, its configuration bit 18 (halt) is 0 and its count field (control bits 11:0) is nonzero. Otherwise it issues no memory access and its enable bit is left as it is.
- R2: The flow code is configuration bits 13:11. The source peripheral index is bits 5:1 and the destination peripheral index is bits 10:6, and the request vector is `req_single | req_burst`. Code 0 always runs, code 1 needs the destination request, code 2 needs the source request and code 3 needs both. Codes 4 to 7 never run.
- R3: Each element is a read of 1 << control[19:18] bytes from the source address followed by a write of the same bytes to the destination address. `mem_size` carries the log2 byte count, and the element sits in the low bytes of the data buses. Only equal source and destination widths of 1, 2 or 4 bytes are used.
- R4: After an element, the source address advances by the element width when control bit 26 is 1, and the destination address advances by the same width when control bit 27 is 1. An address whose bit is 0 stays fixed.
- R5: Each element decrements the count by one and leaves control bits 31:12 unchanged. A block of N elements therefore produces exactly N writes.
- R6: When the count reaches zero and the pointer P is nonzero, the engine issues four word reads in this order: P+0 (new source), P+4 (new destination), P+12 (new control), then P+8 (new pointer). The channel then continues with the reloaded context.
- R7: When the count reaches zero and the pointer is zero, the channel's enable bit clears and `ch_enabled` for that channel falls. No channel's enable rises except through a host configuration write.
- R8: At the end of a block, `tc_pulse` for that channel is 1 for one cycle if bit 31 of the control word is 1. After a reload, the reloaded control word is the one tested. At most one `tc_pulse` bit is set at a time.
- R9: The engine looks at one channel per cycle, in rising index order with wrap-around. It keeps servicing the same channel until that channel is no longer eligible, so two channels' elements never interleave.
- R10: A memory request stays stable until `mem_ready` accepts it. A write completes at acceptance. After an accepted read, no new request is issued until `mem_rvalid` returns the data.
- R11: While `rst` is 1 there is no memory request and no terminal-count pulse, and on the following cycle every channel enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable for all channels |
| cfg_we | input | 1 | Host write strobe for a channel context word |
| cfg_ch | input | CW | Channel selected by the host write |
| cfg_sel | input | 3 | Context word: 0 source, 1 destination, 2 pointer, 3 control, 4 configuration |
| cfg_wdata | input | 32 | Host write data |
| req_single | input | 32 | Single-transfer peripheral requests |
| req_burst | input | 32 | Burst peripheral requests |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data, element in the low bytes |
| mem_size | output | 2 | log2 of the access size in bytes |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, element in the low bytes |
| tc_pulse | output | NCH | One-cycle terminal-count pulse per channel |
| ch_enabled | output | NCH | Current enable bit of each channel |

## Verification
The assertions assume that the memory side returns exactly one `mem_rvalid` for each accepted read and never returns one unsolicited. They also assume that the element size field always holds 0, 1 or 2, and that the host never rewrites a channel while the engine is moving data for it. The stimulus keeps to these assumptions. A responder answers only reads it has accepted, after a random delay of zero to two cycles. Control words are built with legal sizes only. Every context is written either with `glb_en` low or with the configuration word written last, and only to channels that are idle. Descriptors and data buffers occupy separate memory regions, so the reload reads never see data written by a transfer.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int WORD_W = 32;
    localparam int REQ_W  = 32;

    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_HALT_BIT = 18;
    localparam int CTL_SINC_BIT = 26;
    localparam int CTL_DINC_BIT = 27;
    localparam int CTL_TC_BIT   = 31;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] lli;
        logic [WORD_W-1:0] ctl;
        logic [WORD_W-1:0] cfg;
    } chan_t;

    typedef enum logic [2:0] {
        SEL_SRC = 3'd0,
        SEL_DST = 3'd1,
        SEL_LLI = 3'd2,
        SEL_CTL = 3'd3,
        SEL_CFG = 3'd4
    } sel_t;

    typedef enum logic [2:0] {
        ST_SCAN,
        ST_RD,
        ST_RDW,
        ST_WR,
        ST_LL,
        ST_LLW,
        ST_DONE
    } st_t;

    function automatic logic [11:0] ctl_count(logic [WORD_W-1:0] ctl);
        return ctl[11:0];
    endfunction

    function automatic logic [1:0] ctl_size(logic [WORD_W-1:0] ctl);
        return ctl[19:18];
    endfunction

    // Flow gate: code in cfg[13:11], src index cfg[5:1], dst index cfg[10:6]
    function automatic logic flow_ok(logic [WORD_W-1:0] cfg, logic [REQ_W-1:0] req);
        logic s_rq;
        logic d_rq;
        s_rq = req[cfg[5:1]];
        d_rq = req[cfg[10:6]];
        case (cfg[13:11])
            3'd0:    return 1'b1;
            3'd1:    return d_rq;
            3'd2:    return s_rq;
            3'd3:    return s_rq & d_rq;
            default: return 1'b0;
        endcase
    endfunction

    // Descriptor fetch order: source, destination, control, next pointer
    function automatic logic [WORD_W-1:0] desc_offset(logic [1:0] idx);
        case (idx)
            2'd0:    return 32'd0;
            2'd1:    return 32'd4;
            2'd2:    return 32'd12;
            default: return 32'd8;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_eng_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_we,
    input  logic [CW-1:0]         host_ch,
    input  logic [2:0]            host_sel,
    input  logic [WORD_W-1:0]     host_data,
    input  logic                  upd_valid,
    input  logic [CW-1:0]         upd_ch,
    input  chan_t                 upd_val,
    output chan_t [NCH-1:0]       regs_o
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_o[i] <= '0;
            end else if (upd_valid && upd_ch == CW'(i)) begin
                regs_o[i] <= upd_val;
            end else if (host_we && host_ch == CW'(i)) begin
                case (sel_t'(host_sel))
                    SEL_SRC: regs_o[i].src <= host_data;
                    SEL_DST: regs_o[i].dst <= host_data;
                    SEL_LLI: regs_o[i].lli <= host_data;
                    SEL_CTL: regs_o[i].ctl <= host_data;
                    SEL_CFG: regs_o[i].cfg <= host_data;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dma_elig.sv
module dma_elig
    import dma_eng_pkg::*;
#(
    parameter int NCH = 4
) (
    input  chan_t [NCH-1:0]   regs_i,
    input  logic [REQ_W-1:0]  req_i,
    input  logic              glb_en,
    output logic [NCH-1:0]    elig_o
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic unused_fields;
        assign unused_fields = ^{regs_i[i].src, regs_i[i].dst, regs_i[i].lli,
                                 regs_i[i].ctl[31:12], regs_i[i].cfg[31:19],
                                 regs_i[i].cfg[17:14]};
        assign elig_o[i] = glb_en
                         && regs_i[i].cfg[CFG_EN_BIT]
                         && !regs_i[i].cfg[CFG_HALT_BIT]
                         && (ctl_count(regs_i[i].ctl) != 12'd0)
                         && flow_ok(regs_i[i].cfg, req_i);
    end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_eng_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCH-1:0]      elig_i,
    input  chan_t [NCH-1:0]     regs_i,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic                mem_write,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic [1:0]          mem_size,
    input  logic                mem_rvalid,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                upd_valid,
    output logic [CW-1:0]       upd_ch,
    output chan_t               upd_val,
    output logic [NCH-1:0]      tc_o
);

    st_t                st;
    logic [CW-1:0]      cur;
    chan_t              w;
    logic [WORD_W-1:0]  data;
    logic [1:0]         ll_idx;
    logic               tc_pend;
    logic [WORD_W-1:0]  step;

    always_comb begin
        step      = 32'd1 << ctl_size(w.ctl);
        mem_valid = (st == ST_RD) || (st == ST_WR) || (st == ST_LL);
        mem_write = (st == ST_WR);
        mem_wdata = data;
        mem_size  = (st == ST_LL) ? 2'd2 : ctl_size(w.ctl);
        case (st)
            ST_RD:   mem_addr = w.src;
            ST_WR:   mem_addr = w.dst;
            default: mem_addr = w.lli + desc_offset(ll_idx);
        endcase
        upd_valid = (st == ST_DONE);
        upd_ch    = cur;
        upd_val   = w;
        tc_o      = (st == ST_DONE && tc_pend) ? (NCH'(1) << cur) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_SCAN;
            cur     <= '0;
            w       <= '0;
            data    <= '0;
            ll_idx  <= '0;
            tc_pend <= 1'b0;
        end else begin
            case (st)
                ST_SCAN: begin
                    if (elig_i[cur]) begin
                        w  <= regs_i[cur];
                        st <= ST_RD;
                    end else begin
                        cur <= (cur == CW'(NCH - 1)) ? '0 : cur + 1'b1;
                    end
                end
                ST_RD: if (mem_ready) st <= ST_RDW;
                ST_RDW: begin
                    if (mem_rvalid) begin
                        data <= mem_rdata;
                        st   <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_ready) begin
                        if (w.ctl[CTL_SINC_BIT]) w.src <= w.src + step;
                        if (w.ctl[CTL_DINC_BIT]) w.dst <= w.dst + step;
                        w.ctl[11:0] <= w.ctl[11:0] - 12'd1;
                        tc_pend     <= 1'b0;
                        ll_idx      <= '0;
                        if (ctl_count(w.ctl) == 12'd1) begin
                            if (w.lli != '0) begin
                                st <= ST_LL;
                            end else begin
                                w.cfg[CFG_EN_BIT] <= 1'b0;
                                tc_pend           <= w.ctl[CTL_TC_BIT];
                                st                <= ST_DONE;
                            end
                        end else begin
                            st <= ST_DONE;
                        end
                    end
                end
                ST_LL: if (mem_ready) st <= ST_LLW;
                ST_LLW: begin
                    if (mem_rvalid) begin
                        case (ll_idx)
                            2'd0:    w.src <= mem_rdata;
                            2'd1:    w.dst <= mem_rdata;
                            2'd2:    w.ctl <= mem_rdata;
                            default: w.lli <= mem_rdata;
                        endcase
                        ll_idx <= ll_idx + 2'd1;
                        if (ll_idx == 2'd3) begin
                            tc_pend <= w.ctl[CTL_TC_BIT];
                            st      <= ST_DONE;
                        end else begin
                            st <= ST_LL;
                        end
                    end
                end
                default: st <= ST_SCAN;
            endcase
        end
    end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_eng_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              glb_en,
    input  logic              cfg_we,
    input  logic [CW-1:0]     cfg_ch,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [31:0]       req_single,
    input  logic [31:0]       req_burst,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [1:0]        mem_size,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic [NCH-1:0]    tc_pulse,
    output logic [NCH-1:0]    ch_enabled
);

    chan_t [NCH-1:0] regs;
    logic  [NCH-1:0] elig;
    logic            upd_valid;
    logic  [CW-1:0]  upd_ch;
    chan_t           upd_val;

    dma_chan_regs #(.NCH(NCH)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .host_we   (cfg_we),
        .host_ch   (cfg_ch),
        .host_sel  (cfg_sel),
        .host_data (cfg_wdata),
        .upd_valid (upd_valid),
        .upd_ch    (upd_ch),
        .upd_val   (upd_val),
        .regs_o    (regs)
    );

    dma_elig #(.NCH(NCH)) elig_i (
        .regs_i (regs),
        .req_i  (req_single | req_burst),
        .glb_en (glb_en),
        .elig_o (elig)
    );

    dma_seq #(.NCH(NCH)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .elig_i     (elig),
        .regs_i     (regs),
        .mem_valid  (mem_valid),
        .mem_ready  (mem_ready),
        .mem_write  (mem_write),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_size   (mem_size),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .upd_valid  (upd_valid),
        .upd_ch     (upd_ch),
        .upd_val    (upd_val),
        .tc_o       (tc_pulse)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_en
        assign ch_enabled[i] = regs[i].cfg[CFG_EN_BIT];
    end

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
    parameter int NCH = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_we,
    input logic            mem_valid,
    input logic            mem_ready,
    input logic            mem_write,
    input logic [31:0]     mem_addr,
    input logic [31:0]     mem_wdata,
    input logic [1:0]      mem_size,
    input logic            mem_rvalid,
    input logic [NCH-1:0]  tc_pulse,
    input logic [NCH-1:0]  ch_enabled
);

    logic rd_open;

    always_ff @(posedge clk) begin
        if (rst)                                     rd_open <= 1'b0;
        else if (mem_valid && mem_ready && !mem_write) rd_open <= 1'b1;
        else if (mem_rvalid)                         rd_open <= 1'b0;
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)
                                    && $stable(mem_size) && $stable(mem_wdata));

    // R10
    one_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_open |-> !mem_valid);

    // R8
    tc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tc_pulse));

    // R3
    size_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> mem_size <= 2'd2);

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !mem_valid && tc_pulse == '0 && ch_enabled == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_en
        // R7
        en_rise_chk: assert property (@(posedge clk) disable iff (rst)
            !cfg_we |=> !$rose(ch_enabled[i]));
    end

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.NCH(NCH)) chk_i (.*);

// File: tb/dma_xfer_engine_tb_top.sv
module dma_xfer_engine_tb_top;

    localparam int NCH = 4;
    localparam int MSZ = 4096;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            glb_en = 1'b0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_ch = '0;
    logic [2:0]      cfg_sel = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [31:0]     req_single = '0;
    logic [31:0]     req_burst = '0;
    logic            mem_valid;
    logic            mem_ready = 1'b0;
    logic            mem_write;
    logic [31:0]     mem_addr;
    logic [31:0]     mem_wdata;
    logic [1:0]      mem_size;
    logic            mem_rvalid = 1'b0;
    logic [31:0]     mem_rdata = '0;
    logic [NCH-1:0]  tc_pulse;
    logic [NCH-1:0]  ch_enabled;

    always #4 clk = ~clk;

    dma_xfer_engine #(.NCH(NCH)) dut_i (.*);

    logic [7:0]  mem     [MSZ];
    logic [7:0]  exp_mem [MSZ];
    logic [31:0] rd_log  [256];
    logic [31:0] wr_log  [256];
    int          tc_cnt  [NCH];
    int          rd_n, wr_n, proto_bad;
    int          n_chk = 0;
    int          n_bad = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] rd32(input logic [31:0] a);
        logic [31:0] v;
        for (int b = 0; b < 4; b++) v[8*b +: 8] = exp_mem[12'(a + 32'(b))];
        return v;
    endfunction

    task automatic put32(input logic [31:0] a, input logic [31:0] v);
        for (int b = 0; b < 4; b++) mem[12'(a + 32'(b))] = v[8*b +: 8];
    endtask

    function automatic logic [31:0] mk_ctl(input int cnt, input int sz, input bit si,
                                           input bit di, input bit tc);
        return (32'(tc) << 31) | (32'(di) << 27) | (32'(si) << 26) |
               (32'(sz) << 21) | (32'(sz) << 18) | 32'(cnt);
    endfunction

    function automatic int mem_diff();
        for (int i = 0; i < MSZ; i++) if (mem[i] !== exp_mem[i]) return i;
        return -1;
    endfunction

    task automatic sync_exp();
        for (int i = 0; i < MSZ; i++) exp_mem[i] = mem[i];
    endtask

    task automatic clr_logs();
        rd_n = 0; wr_n = 0;
        for (int c = 0; c < NCH; c++) tc_cnt[c] = 0;
    endtask

    // Reference: expected memory effect, write count and pulse count of one channel
    task automatic model(input logic [31:0] s0, input logic [31:0] d0, input logic [31:0] l0,
                         input logic [31:0] c0, output int nwr, output int ntc);
        logic [31:0] s, d, l, ct, nx;
        int w;
        s = s0; d = d0; l = l0; ct = c0; nwr = 0; ntc = 0;
        forever begin
            if (ct[11:0] == 12'd0) break;
            w = 1 << ct[19:18];
            for (int k = 0; k < int'(ct[11:0]); k++) begin
                for (int b = 0; b < w; b++) exp_mem[12'(d + 32'(b))] = exp_mem[12'(s + 32'(b))];
                if (ct[26]) s = s + 32'(w);
                if (ct[27]) d = d + 32'(w);
                nwr++;
            end
            if (l == 32'd0) begin
                if (ct[31]) ntc++;
                break;
            end
            nx = l;
            s = rd32(nx); d = rd32(nx + 4); ct = rd32(nx + 12); l = rd32(nx + 8);
            if (ct[31]) ntc++;
        end
    endtask

    task automatic wcfg(input int c, input int sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(c); cfg_sel = 3'(sel); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(input int c, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] l, input logic [31:0] ct, input logic [31:0] cf);
        wcfg(c, 0, s); wcfg(c, 1, d); wcfg(c, 2, l); wcfg(c, 3, ct); wcfg(c, 4, cf);
    endtask

    task automatic wait_off(input int c, input string rq);
        int t;
        t = 0;
        while (ch_enabled[c] && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk(!ch_enabled[c], rq, ch_enabled[c], 0);
    endtask

    // Memory side: sampled and driven on the falling edge
    task automatic serve();
        bit          pend;
        int          dly;
        logic [31:0] pdata;
        logic [11:0] a;
        pend = 0; dly = 0; pdata = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            for (int c = 0; c < NCH; c++) if (tc_pulse[c]) tc_cnt[c]++;
            if (pend) begin
                if (dly == 0) begin
                    mem_rvalid = 1'b1; mem_rdata = pdata; pend = 0;
                end else begin
                    dly--;
                end
            end
            if (pend && mem_valid) proto_bad++;
            mem_ready = ($urandom_range(3) != 0);
            if (mem_valid && mem_ready && !rst) begin
                a = mem_addr[11:0];
                if (mem_write) begin
                    for (int b = 0; b < (1 << mem_size); b++) mem[12'(a + 12'(b))] = mem_wdata[8*b +: 8];
                    if (wr_n < 256) wr_log[wr_n] = mem_addr;
                    wr_n++;
                end else begin
                    pdata = '0;
                    for (int b = 0; b < (1 << mem_size); b++) pdata[8*b +: 8] = mem[12'(a + 12'(b))];
                    pend = 1; dly = $urandom_range(2);
                    if (rd_n < 256) rd_log[rd_n] = mem_addr;
                    rd_n++;
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int nwr, ntc, sw;
        logic [31:0] ct, s, d;
        void'($urandom(32'd4242));
        for (int i = 0; i < MSZ; i++) mem[i] = 8'($urandom);
        proto_bad = 0;
        clr_logs();
        fork serve(); join_none

        // R11 reset state
        repeat (3) @(negedge clk);
        chk(!mem_valid, "R11 mem_valid in reset", mem_valid, 0);
        chk(ch_enabled == '0, "R11 enables in reset", ch_enabled, 0);
        chk(tc_pulse == '0, "R11 tc in reset", tc_pulse, 0);
        rst = 1'b0;

        // R1 global enable gate, then R3 R5 R8 basic block
        clr_logs(); sync_exp();
        ct = mk_ctl(4, 2, 1, 1, 1);
        prog(0, 32'h200, 32'h800, 0, ct, 32'h1);
        repeat (40) @(negedge clk);
        chk(wr_n == 0 && rd_n == 0, "R1 global enable off", wr_n + rd_n, 0);
        model(32'h200, 32'h800, 0, ct, nwr, ntc);
        glb_en = 1'b1;
        wait_off(0, "R7 end of block");
        chk(mem_diff() == -1, "R3 memory image", mem_diff(), -1);
        chk(wr_n == nwr, "R5 element count", wr_n, nwr);
        chk(tc_cnt[0] == 1, "R8 tc on last element", tc_cnt[0], 1);

        // R1 halt bit
        clr_logs(); sync_exp();
        ct = mk_ctl(3, 1, 1, 1, 0);
        prog(1, 32'h240, 32'h840, 0, ct, 32'h1 | (32'h1 << 18));
        repeat (40) @(negedge clk);
        chk(wr_n == 0 && ch_enabled[1], "R1 halted channel idle", wr_n, 0);
        model(32'h240, 32'h840, 0, ct, nwr, ntc);
        wcfg(1, 4, 32'h1);
        wait_off(1, "R7 after halt release");
        chk(mem_diff() == -1, "R1 run after halt cleared", mem_diff(), -1);
        chk(tc_cnt[1] == 0, "R8 no tc when bit 31 clear", tc_cnt[1], 0);

        // R1 zero count is skipped and stays enabled
        clr_logs();
        prog(2, 32'h260, 32'h860, 0, mk_ctl(0, 2, 1, 1, 1), 32'h1);
        repeat (40) @(negedge clk);
        chk(wr_n == 0 && rd_n == 0, "R1 zero count no access", wr_n + rd_n, 0);
        chk(ch_enabled[2] == 1'b1, "R1 zero count stays enabled", ch_enabled[2], 1);
        wcfg(2, 4, 32'h0);

        // R2 flow control gating
        clr_logs(); sync_exp();
        ct = mk_ctl(2, 2, 1, 1, 0);
        prog(0, 32'h300, 32'h900, 0, ct, 32'h1 | (32'd7 << 6) | (32'd1 << 11));
        prog(1, 32'h340, 32'h940, 0, ct, 32'h1 | (32'd4 << 11));
        repeat (40) @(negedge clk);
        chk(wr_n == 0, "R2 code 1 waits for dst request", wr_n, 0);
        model(32'h300, 32'h900, 0, ct, nwr, ntc);
        req_burst = 32'h1 << 7;
        wait_off(0, "R2 code 1 runs on burst request");
        req_single = '1;
        repeat (40) @(negedge clk);
        chk(ch_enabled[1] && wr_n == nwr, "R2 code 4 never runs", wr_n, nwr);
        chk(mem_diff() == -1, "R2 only gated channel moved", mem_diff(), -1);
        wcfg(1, 4, 32'h0);
        req_single = 32'h1 << 3; req_burst = '0;
        clr_logs(); sync_exp();
        ct = mk_ctl(3, 0, 1, 1, 0);
        prog(2, 32'h380, 32'h980, 0, ct, 32'h1 | (32'd3 << 1) | (32'd9 << 6) | (32'd3 << 11));
        repeat (40) @(negedge clk);
        chk(wr_n == 0, "R2 code 3 needs both requests", wr_n, 0);
        model(32'h380, 32'h980, 0, ct, nwr, ntc);
        req_burst = 32'h1 << 9;
        wait_off(2, "R2 code 3 runs with both");
        chk(mem_diff() == -1, "R2 code 3 data", mem_diff(), -1);
        req_single = '0; req_burst = '0;

        // R9 channels are serviced without interleaving
        glb_en = 1'b0;
        clr_logs(); sync_exp();
        ct = mk_ctl(3, 0, 1, 1, 0);
        prog(0, 32'h3a0, 32'h880, 0, ct, 32'h1);
        prog(1, 32'h3c0, 32'h8c0, 0, ct, 32'h1);
        model(32'h3a0, 32'h880, 0, ct, nwr, ntc);
        model(32'h3c0, 32'h8c0, 0, ct, nwr, ntc);
        glb_en = 1'b1;
        wait_off(0, "R9 first channel done");
        wait_off(1, "R9 second channel done");
        sw = 0;
        for (int i = 1; i < 6; i++) if ((wr_log[i] < 32'h8c0) != (wr_log[i-1] < 32'h8c0)) sw++;
        chk(sw == 1 && wr_n == 6, "R9 no interleaving", sw, 1);
        chk(mem_diff() == -1, "R9 data", mem_diff(), -1);

        // R6 R7 R8 descriptor chain
        clr_logs();
        put32(32'hf00, 32'h3e0); put32(32'hf04, 32'ha00);
        put32(32'hf08, 32'hf20); put32(32'hf0c, mk_ctl(3, 1, 1, 1, 1));
        put32(32'hf20, 32'h3f0); put32(32'hf24, 32'ha40);
        put32(32'hf28, 32'h0);   put32(32'hf2c, mk_ctl(1, 2, 1, 0, 1));
        sync_exp();
        ct = mk_ctl(2, 2, 1, 1, 0);
        model(32'h3d0, 32'h9c0, 32'hf00, ct, nwr, ntc);
        prog(3, 32'h3d0, 32'h9c0, 32'hf00, ct, 32'h1);
        wait_off(3, "R7 chain ends on zero pointer");
        chk(rd_log[2] == 32'hf00 && rd_log[3] == 32'hf04, "R6 fetch src then dst", rd_log[3], 32'hf04);
        chk(rd_log[4] == 32'hf0c && rd_log[5] == 32'hf08, "R6 fetch ctl then next", rd_log[5], 32'hf08);
        chk(mem_diff() == -1, "R6 chained data", mem_diff(), -1);
        chk(wr_n == nwr, "R5 chained element count", wr_n, nwr);
        chk(tc_cnt[3] == ntc && tc_cnt[0] + tc_cnt[1] + tc_cnt[2] == 0, "R8 reloaded ctl tested", tc_cnt[3], ntc);

        // R3 R4 R5 R8 random blocks
        for (int it = 0; it < 24; it++) begin
            int c, sz, cnt;
            bit si, di, tc;
            c = $urandom_range(NCH - 1);
            sz = $urandom_range(2); cnt = $urandom_range(8, 1);
            si = 1'($urandom); di = 1'($urandom); tc = 1'($urandom);
            s = 32'h200 + 32'($urandom_range(15)) * 4;
            d = 32'h800 + 32'($urandom_range(31)) * 4;
            ct = mk_ctl(cnt, sz, si, di, tc);
            clr_logs(); sync_exp();
            model(s, d, 0, ct, nwr, ntc);
            prog(c, s, d, 0, ct, 32'h1);
            wait_off(c, "R7 random block end");
            chk(mem_diff() == -1, "R4 random memory image", mem_diff(), -1);
            chk(wr_n == nwr, "R5 random element count", wr_n, nwr);
            chk(tc_cnt[c] == ntc, "R8 random tc", tc_cnt[c], ntc);
        end

        chk(proto_bad == 0, "R10 single outstanding read", proto_bad, 0);
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule